// File: doc/BRIEF.md
# Stack Arithmetic Processor Core

This block is a very small processor whose only architectural state is an on-chip stack of signed values and a pointer that counts how many stack entries are in use. One instruction arrives per clock cycle. It is either a push of an immediate value or one of three binary operators: addition, multiplication and subtraction. The core updates the stack at the next clock edge. In the same cycle, it presents the value the instruction produces on its result output, so a consumer sees each result without waiting a cycle.

A binary operator takes its two operands from the top of the stack. It replaces them with a single entry that holds the result, so the pointer drops by one. The stack storage is written at exactly one indexed slot per cycle through a decoded per-entry write enable. No logic rebuilds the whole array on every write.

The core flags an illegal instruction on its error output for the cycle in which it is issued. An illegal instruction is a push onto a full stack, or an operator issued when fewer than two entries are in use. Such an instruction leaves the stack untouched. When no instruction is presented, the core holds its state and drives a zero result.

Top module: `stack_alu_core`

## Requirements
- R1: After reset is released, the stack is empty: the first binary operator issued raises error and returns a zero result.
- R2: The opcode is decoded as 2'b00 push, 2'b01 add, 2'b10 multiply and 2'b11 subtract. A legal push drives the immediate on result in the same cycle.
- R3: A legal add drives result = second + top (modulo 2^16) in the same cycle and leaves that sum as the new top entry.
- R4: A legal multiply drives the low 16 bits of second × top in the same cycle and leaves them as the new top entry.
- R5: A legal subtract drives result = second − top (modulo 2^16) in the same cycle and leaves that difference as the new top entry.
- R6: A legal push raises the occupancy by one, and a legal binary operator lowers it by one, so entries beneath the operands are preserved.
- R7: A push issued while all 8 entries are occupied raises error for that cycle, gives a zero result and changes neither the stack nor the pointer.
- R8: A binary operator issued with fewer than 2 occupied entries raises error for that cycle, gives a zero result and changes neither the stack nor the pointer.
- R9: While instruction-valid is low, result is zero, error is low, and the stack and pointer hold, whatever the opcode and immediate are.
- R10: The program push 45, push 2, add, push 3, mul, push 100, sub, push 0, push 1, sub yields 45, 2, 47, 3, 141, 100, 41, 0, 1, −1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; empties the stack |
| instr_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 2 | Instruction code (see R2) |
| imm | input | 16 | Immediate value used by push |
| result | output | 16 | Value produced by the current instruction (combinational) |
| error | output | 1 | Current instruction is illegal (overflow or underflow) |

## Verification
Result and error are combinational from the presented instruction and the current stack, so they are due in the same cycle the instruction is driven. The stack and pointer change only at the following rising edge, so their effect shows up in the outputs of the next instruction. The bench drives inputs just after the falling edge and samples both outputs shortly before the rising edge that commits the instruction. Its expected values come from an arithmetic model that it advances only after that edge. Illegal and idle cycles are judged both by their own outputs and by the results of the instructions that follow them, which expose whether any stack entry was disturbed.

// File: rtl/stk_pkg.sv
// Package: shared opcode type for the stack arithmetic core.
// Assumes a 2-bit opcode field; the encoding is architectural.
package stk_pkg;
    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_ADD  = 2'b01,
        OP_MUL  = 2'b10,
        OP_SUB  = 2'b11
    } stk_op_e;
endpackage

// File: rtl/stk_ctrl.sv
// Module: stk_ctrl
// Holds the occupancy pointer and decides legality and slot addresses.
// Assumes DEPTH >= 2; the pointer counts occupied entries (0..DEPTH).
module stk_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  stk_pkg::stk_op_e op,
    output logic             fault,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] top_idx,
    output logic [IDX_W-1:0] nxt_idx,
    output logic [PTR_W-1:0] sp_q
);
    import stk_pkg::*;

    logic is_push;
    logic push_ok;
    logic bin_ok;

    // Classify the instruction and detect overflow / underflow.
    always_comb begin
        is_push = (op == OP_PUSH);
        push_ok = instr_valid && is_push && (sp_q != PTR_W'(DEPTH));
        bin_ok  = instr_valid && !is_push && (sp_q >= PTR_W'(2));
        fault   = instr_valid && !push_ok && !bin_ok;
        wr_en   = push_ok || bin_ok;
    end

    // Derive read slots (top and second) and the single write slot.
    always_comb begin
        top_idx = IDX_W'(sp_q - PTR_W'(1));
        nxt_idx = IDX_W'(sp_q - PTR_W'(2));
        wr_idx  = is_push ? IDX_W'(sp_q) : nxt_idx;
    end

    // Advance the occupancy pointer on legal instructions only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (push_ok)
            sp_q <= sp_q + PTR_W'(1);
        else if (bin_ok)
            sp_q <= sp_q - PTR_W'(1);
    end
endmodule

// File: rtl/stk_regfile.sv
// Module: stk_regfile
// Stack storage with one write port and two read ports.
// Each entry has its own decoded enable, so a write touches one slot only.
// Assumes storage needs no reset: unoccupied entries are never read legally.
module stk_regfile #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic slot_we;
        // Decode this entry's write enable from the shared index.
        assign slot_we = wr_en && (wr_idx == IDX_W'(g));
        // Capture new data into this entry only when addressed.
        always_ff @(posedge clk) begin
            if (slot_we)
                mem[g] <= wr_data;
        end
    end

    // Read the top and second operands.
    always_comb begin
        rd_a = mem[rd_a_idx];
        rd_b = mem[rd_b_idx];
    end
endmodule

// File: rtl/stk_alu.sv
// Module: stk_alu
// Combinational datapath producing the value an instruction yields.
// All arithmetic wraps modulo 2^DATA_W; the product keeps its low bits.
module stk_alu #(
    parameter int DATA_W = 16
) (
    input  stk_pkg::stk_op_e  op,
    input  logic [DATA_W-1:0] imm,
    input  logic [DATA_W-1:0] top,
    input  logic [DATA_W-1:0] nxt,
    output logic [DATA_W-1:0] res
);
    import stk_pkg::*;

    // Select the push value or the operator result.
    always_comb begin
        unique case (op)
            OP_PUSH: res = imm;
            OP_ADD:  res = nxt + top;
            OP_MUL:  res = nxt * top;
            OP_SUB:  res = nxt - top;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/stack_alu_core.sv
// Module: stack_alu_core (top)
// Stack processor: one push/add/mul/sub instruction per cycle. The result
// is forwarded combinationally in the same cycle and committed at the edge.
// Assumes a synchronous active-low reset and instructions held stable for
// the whole cycle.
module stack_alu_core #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [1:0]        opcode,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] result,
    output logic              error
);
    import stk_pkg::*;

    stk_op_e           op;
    logic              fault;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  nxt_idx;
    logic [PTR_W-1:0]  sp_q;
    logic [DATA_W-1:0] top_val;
    logic [DATA_W-1:0] nxt_val;
    logic [DATA_W-1:0] alu_res;

    assign op = stk_op_e'(opcode);

    stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .op          (op),
        .fault       (fault),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .top_idx     (top_idx),
        .nxt_idx     (nxt_idx),
        .sp_q        (sp_q)
    );

    stk_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rf (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (alu_res),
        .rd_a_idx (top_idx),
        .rd_b_idx (nxt_idx),
        .rd_a     (top_val),
        .rd_b     (nxt_val)
    );

    stk_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (op),
        .imm (imm),
        .top (top_val),
        .nxt (nxt_val),
        .res (alu_res)
    );

    // Forward the result only for legal, valid instructions.
    always_comb begin
        result = (instr_valid && !fault) ? alu_res : '0;
        error  = fault;
    end
endmodule

// File: rtl/stack_alu_core_chk.sv
// Module: stack_alu_core_chk
// Property checker bound into stack_alu_core; observes ports and pointer.
module stack_alu_core_chk #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [1:0]        opcode,
    input logic [DATA_W-1:0] imm,
    input logic [DATA_W-1:0] result,
    input logic              error,
    input logic [PTR_W-1:0]  sp_q
);
    assert_empty_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> sp_q == '0);

    assert_push_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opcode == 2'b00 && !error) |-> result == imm);

    assert_push_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opcode == 2'b00 && !error) |=> sp_q == $past(sp_q) + PTR_W'(1));

    assert_binop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opcode != 2'b00 && !error) |=> sp_q == $past(sp_q) - PTR_W'(1));

    assert_ptr_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= PTR_W'(DEPTH));

    assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opcode == 2'b00 && sp_q == PTR_W'(DEPTH)) |-> (error && result == '0));

    assert_underflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opcode != 2'b00 && sp_q < PTR_W'(2)) |-> (error && result == '0));

    assert_fault_holds_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> $stable(sp_q));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (result == '0 && !error));

    assert_idle_holds_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(sp_q));
endmodule

bind stack_alu_core stack_alu_core_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .opcode      (opcode),
    .imm         (imm),
    .result      (result),
    .error       (error),
    .sp_q        (sp_q)
);

// File: tb/stack_alu_core_bench.sv
// Bench: sweeps operand pairs for every operator, plus overflow, underflow,
// idle and program-sequence cases, against an arithmetic stack model.
module stack_alu_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic [15:0] imm = '0;
    logic [15:0] result;
    logic        error;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [15:0] m_stk [DEPTH];
    int          m_sp = 0;

    stack_alu_core u_stack_alu_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .opcode      (opcode),
        .imm         (imm),
        .result      (result),
        .error       (error)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_sp = 0;
    endtask

    // Issue one instruction, compare outputs in-cycle, then advance model.
    task automatic exec(logic v, logic [1:0] op, logic [15:0] x, output logic [15:0] got);
        logic        e_err;
        logic [15:0] e_res;
        logic [15:0] a;
        logic [15:0] b;
        string       tag;
        @(negedge clk);
        instr_valid = v;
        opcode = op;
        imm = x;
        e_err = v && ((op == 2'b00 && m_sp == DEPTH) || (op != 2'b00 && m_sp < 2));
        a = (m_sp >= 2) ? m_stk[m_sp-2] : '0;
        b = (m_sp >= 1) ? m_stk[m_sp-1] : '0;
        if (!v || e_err) e_res = '0;
        else case (op)
            2'b00:   e_res = x;
            2'b01:   e_res = a + b;
            2'b10:   e_res = a * b;
            default: e_res = a - b;
        endcase
        if (!v)                 tag = "R9 idle";
        else if (e_err && op == 2'b00) tag = "R7 overflow";
        else if (e_err)         tag = "R8 underflow";
        else if (op == 2'b00)   tag = "R2 push";
        else if (op == 2'b01)   tag = "R3 add";
        else if (op == 2'b10)   tag = "R4 mul";
        else                    tag = "R5 sub";
        #(CLK_PERIOD / 2 - 2);
        chk({tag, " result"}, result, e_res);
        chk({tag, " error"}, {15'b0, error}, {15'b0, e_err});
        got = result;
        @(posedge clk);
        if (v && !e_err) begin
            if (op == 2'b00) begin
                m_stk[m_sp] = x;
                m_sp++;
            end else begin
                m_stk[m_sp-2] = e_res;
                m_sp--;
            end
        end
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES && !done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, MAX_CYCLES);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic [15:0] vals [8];
        logic [15:0] prog_imm [10];
        logic [1:0]  prog_op [10];
        logic [15:0] prog_exp [10];
        vals = '{16'd0, 16'd1, 16'hFFFF, 16'd2, 16'h7FFF, 16'h8000, 16'd300, 16'hFFF9};

        // R1: reset state, first operator underflows.
        do_reset();
        exec(1'b1, 2'b01, 16'd0, got);
        chk("R1 empty after reset", got, 16'd0);

        // R2..R5: sweep operand pairs for each operator.
        for (int op = 1; op < 4; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    do_reset();
                    exec(1'b1, 2'b00, vals[i], got);
                    exec(1'b1, 2'b00, vals[j], got);
                    exec(1'b1, 2'(op), 16'd0, got);
                end
            end
        end

        // R6: deeper stacks keep lower entries through operators.
        do_reset();
        exec(1'b1, 2'b00, 16'd10, got);
        exec(1'b1, 2'b00, 16'd20, got);
        exec(1'b1, 2'b00, 16'd7, got);
        exec(1'b1, 2'b11, 16'd0, got);
        chk("R6 sub on third level", got, 16'd13);
        exec(1'b1, 2'b01, 16'd0, got);
        chk("R6 preserved bottom entry", got, 16'd23);
        exec(1'b1, 2'b10, 16'd0, got);
        chk("R6 single entry left", {15'b0, error}, 16'd1);

        // R7: overflow on a full stack, then drain to confirm contents.
        do_reset();
        for (int k = 1; k <= DEPTH; k++) exec(1'b1, 2'b00, 16'(k), got);
        exec(1'b1, 2'b00, 16'd99, got);
        chk("R7 overflow flagged", {15'b0, error}, 16'd1);
        for (int k = 0; k < DEPTH - 1; k++) exec(1'b1, 2'b01, 16'd0, got);
        chk("R7 stack intact after overflow", got, 16'd36);

        // R8: underflow with one entry leaves the stack alone.
        do_reset();
        exec(1'b1, 2'b00, 16'd4, got);
        exec(1'b1, 2'b11, 16'd0, got);
        exec(1'b1, 2'b00, 16'd9, got);
        exec(1'b1, 2'b11, 16'd0, got);
        chk("R8 stack intact after underflow", got, 16'hFFFB);

        // R9: idle cycles with every opcode change nothing.
        do_reset();
        exec(1'b1, 2'b00, 16'd5, got);
        exec(1'b1, 2'b00, 16'd6, got);
        for (int op = 0; op < 4; op++) exec(1'b0, 2'(op), 16'd1234, got);
        exec(1'b1, 2'b11, 16'd0, got);
        chk("R9 stack held while idle", got, 16'hFFFF);

        // R10: program sequence with fixed expected outputs.
        prog_op  = '{2'b00, 2'b00, 2'b01, 2'b00, 2'b10, 2'b00, 2'b11, 2'b00, 2'b00, 2'b11};
        prog_imm = '{16'd45, 16'd2, 16'd0, 16'd3, 16'd0, 16'd100, 16'd0, 16'd0, 16'd1, 16'd0};
        prog_exp = '{16'd45, 16'd2, 16'd47, 16'd3, 16'd141, 16'd100, 16'd41, 16'd0, 16'd1, 16'hFFFF};
        do_reset();
        for (int k = 0; k < 10; k++) begin
            exec(1'b1, prog_op[k], prog_imm[k], got);
            chk("R10 program output", got, prog_exp[k]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule